// File: doc/BRIEF.md
# E1 CAS Multiframe Alignment Monitor

This block follows the channel-associated-signaling multiframe carried in timeslot 16 of an E1 receiver whose basic frame alignment is already established elsewhere. For every received frame it accepts one timeslot-16 byte. It searches that byte stream for the multiframe alignment pattern, which is a zero upper nibble. Once aligned, it numbers the sixteen frames of each multiframe and checks the pattern again at each frame 0.

While searching, a candidate pattern is accepted only if the byte received just before it carries at least one 1 bit. While aligned, two errored alignment patterns in a row cause a one-cycle resync pulse and a return to search. When `ext_mode` is high, a complete multiframe whose timeslot-16 bytes are all zero also causes a resync.

The byte input is a valid/ready stream. `ts_ready` is held high from reset onwards, so the producer never sees back-pressure. A byte is consumed in every cycle in which `ts_valid` is high. Cycles with `ts_valid` low leave all state unchanged.

Top module: `cas_mf_align`

## Requirements
- R1: During and after reset, with no byte yet accepted, `mf_locked` is 0, `mf_frame` is 0, `mf_resync` is 0 and `ts_ready` is 1.
- R2: `ts_ready` is always 1. Each cycle with `ts_valid` high consumes exactly one byte. Cycles with `ts_valid` low change neither `mf_locked` nor `mf_frame`, and `mf_resync` is 0 after them.
- R3: The alignment pattern is `ts_data[7:4] == 4'b0000`, where bit 7 is the first bit of the timeslot on the line. A byte with any 1 in bits 7..4 (for example 0x80 or 0x10) is not a pattern.
- R4: While searching, a pattern byte is accepted as frame 0 only if the previously accepted byte was not 0x00. In the cycle after such a byte, `mf_locked` is 1 and `mf_frame` is 0.
- R5: While aligned, every accepted byte advances `mf_frame` by one, wrapping from 15 to 0. While not aligned, `mf_frame` is 0.
- R6: A single errored pattern (a frame-0 byte with a nonzero upper nibble) keeps the alignment, and the frame count continues. A correct pattern clears the error history.
- R7: A second errored pattern in a row raises `mf_resync` for exactly one cycle, in the cycle after the offending byte. In that same cycle `mf_locked` falls to 0 and `mf_frame` is 0.
- R8: With `ext_mode` = 1, a multiframe (frames 0 to 15) whose bytes are all 0x00 raises `mf_resync` and drops alignment in the cycle after the frame-15 byte. One nonzero bit anywhere in that multiframe prevents this. With `ext_mode` = 0, all-zero multiframes never cause a resync.
- R9: After a resync, search starts again with the next accepted byte. The byte that caused the resync serves as the preceding byte for the R4 test.
- R10: `ext_mode` is sampled together with the frame-15 byte. A value changed during a multiframe governs the decision for that multiframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 0 = basic loss criterion, 1 = basic plus all-zero multiframe criterion |
| ts_valid | input | 1 | A timeslot-16 byte is offered |
| ts_ready | output | 1 | Always 1: every offered byte is taken |
| ts_data | input | 8 | Timeslot-16 byte, bit 7 first on the line |
| mf_locked | output | 1 | Multiframe alignment held |
| mf_frame | output | 4 | Frame number within the multiframe of the last byte accepted |
| mf_resync | output | 1 | One-cycle resync request |

## Verification
The assertions assume that the producer offers exactly one byte per E1 frame, in line order, with no frame skipped. They also assume that `ts_data` is defined whenever `ts_valid` is high. The stimulus drives one byte per valid cycle on the falling clock edge and inserts idle gaps only between whole frames. It changes `ext_mode` only together with a byte, so the sampled mode is always well defined.

// File: rtl/cas_mf_pkg.sv
package cas_mf_pkg;
  typedef enum logic {MF_SEARCH = 1'b0, MF_LOCKED = 1'b1} mf_state_e;
endpackage

// File: rtl/cas_mfas_detect.sv
// Classifies one timeslot-16 byte: pattern in the leading nibble, all zero.
module cas_mfas_detect #(
  parameter int TS_W  = 8,
  parameter int PAT_W = 4
) (
  input  logic [TS_W-1:0] ts,
  output logic            is_pattern,
  output logic            is_zero
);
  localparam int LO_W = TS_W - PAT_W;

  logic [PAT_W-1:0] lead;
  logic [LO_W-1:0]  tail;

  assign lead       = ts[TS_W-1 -: PAT_W];
  assign tail       = ts[LO_W-1:0];
  assign is_pattern = (lead == '0);
  assign is_zero    = is_pattern && (tail == '0);
endmodule

// File: rtl/cas_mf_tracker.sv
// Search/aligned state and the frame-within-multiframe counter.
module cas_mf_tracker
  import cas_mf_pkg::*;
#(
  parameter int MF_LEN = 16,
  localparam int FW = $clog2(MF_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic          acquire,
  input  logic          loss,
  output logic          locked,
  output logic [FW-1:0] frame
);
  localparam logic [FW-1:0] LAST = FW'(MF_LEN - 1);

  mf_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= MF_SEARCH;
      frame <= '0;
    end else if (valid) begin
      unique case (state)
        MF_SEARCH: begin
          frame <= '0;
          if (acquire) state <= MF_LOCKED;
        end
        MF_LOCKED: begin
          if (loss) begin
            state <= MF_SEARCH;
            frame <= '0;
          end else begin
            frame <= (frame == LAST) ? '0 : frame + FW'(1);
          end
        end
        default: state <= MF_SEARCH;
      endcase
    end
  end

  assign locked = (state == MF_LOCKED);
endmodule

// File: rtl/cas_mf_loss.sv
// Loss criteria: consecutive errored patterns, and the all-zero multiframe.
module cas_mf_loss #(
  parameter int MF_LEN    = 16,
  parameter int ERR_LIMIT = 2,
  localparam int FW = $clog2(MF_LEN),
  localparam int EW = $clog2(ERR_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic          acquire,
  input  logic          locked,
  input  logic [FW-1:0] frame,
  input  logic          is_pattern,
  input  logic          is_zero,
  input  logic          ext_mode,
  output logic          loss
);
  localparam logic [FW-1:0] LAST = FW'(MF_LEN - 1);

  logic [EW-1:0] err_cnt;
  logic          zero_run;
  logic [FW-1:0] nxt;
  logic          at_start, at_end, pat_loss, zero_loss;

  assign nxt       = (frame == LAST) ? '0 : frame + FW'(1);
  assign at_start  = locked && (nxt == '0);
  assign at_end    = locked && (nxt == LAST);
  assign pat_loss  = at_start && !is_pattern && (err_cnt == EW'(ERR_LIMIT - 1));
  assign zero_loss = ext_mode && at_end && zero_run && is_zero;
  assign loss      = pat_loss || zero_loss;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_cnt  <= '0;
      zero_run <= 1'b0;
    end else if (valid) begin
      if (acquire) begin
        err_cnt  <= '0;
        zero_run <= is_zero;
      end else if (locked) begin
        if (loss) begin
          err_cnt  <= '0;
          zero_run <= 1'b0;
        end else if (at_start) begin
          err_cnt  <= is_pattern ? '0 : err_cnt + EW'(1);
          zero_run <= is_zero;
        end else begin
          zero_run <= zero_run && is_zero;
        end
      end
    end
  end
endmodule

// File: rtl/cas_mf_align.sv
module cas_mf_align #(
  parameter int TS_W      = 8,
  parameter int PAT_W     = 4,
  parameter int MF_LEN    = 16,
  parameter int ERR_LIMIT = 2,
  localparam int FW = $clog2(MF_LEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_mode,
  input  logic            ts_valid,
  output logic            ts_ready,
  input  logic [TS_W-1:0] ts_data,
  output logic            mf_locked,
  output logic [FW-1:0]   mf_frame,
  output logic            mf_resync
);
  logic is_pattern, is_zero, prev_nz, acquire, loss;

  cas_mfas_detect #(.TS_W(TS_W), .PAT_W(PAT_W)) u_det (
    .ts(ts_data), .is_pattern(is_pattern), .is_zero(is_zero)
  );

  assign acquire  = ts_valid && !mf_locked && is_pattern && prev_nz;
  assign ts_ready = 1'b1;

  cas_mf_tracker #(.MF_LEN(MF_LEN)) u_trk (
    .clk(clk), .rst_n(rst_n), .valid(ts_valid), .acquire(acquire),
    .loss(loss), .locked(mf_locked), .frame(mf_frame)
  );

  cas_mf_loss #(.MF_LEN(MF_LEN), .ERR_LIMIT(ERR_LIMIT)) u_loss (
    .clk(clk), .rst_n(rst_n), .valid(ts_valid), .acquire(acquire),
    .locked(mf_locked), .frame(mf_frame), .is_pattern(is_pattern),
    .is_zero(is_zero), .ext_mode(ext_mode), .loss(loss)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_nz   <= 1'b0;
      mf_resync <= 1'b0;
    end else begin
      mf_resync <= ts_valid && mf_locked && loss;
      if (ts_valid) prev_nz <= (ts_data != '0);
    end
  end
endmodule

// File: rtl/cas_mf_align_chk.sv
module cas_mf_align_chk #(
  parameter int TS_W  = 8,
  parameter int PAT_W = 4,
  parameter int FW    = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ts_valid,
  input logic [TS_W-1:0] ts_data,
  input logic            mf_locked,
  input logic [FW-1:0]   mf_frame,
  input logic            mf_resync
);
  AST_RESYNC_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mf_resync |-> (!mf_locked && mf_frame == '0)); // R7
  AST_RESYNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mf_resync |=> !mf_resync); // R7
  AST_NO_RESYNC_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_locked |=> !mf_resync); // R9
  AST_FRAME_ZERO_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_locked |-> mf_frame == '0); // R5
  AST_LOCK_ON_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mf_locked) |-> ($past(ts_valid) && $past(ts_data[TS_W-1 -: PAT_W]) == '0
                          && mf_frame == '0)); // R4
  AST_FRAME_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_locked && ts_valid) |=> (mf_resync || mf_frame == FW'($past(mf_frame) + 1'b1))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_valid |=> ($stable(mf_frame) && $stable(mf_locked) && !mf_resync)); // R2
endmodule

bind cas_mf_align cas_mf_align_chk #(.TS_W(TS_W), .PAT_W(PAT_W), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid), .ts_data(ts_data),
  .mf_locked(mf_locked), .mf_frame(mf_frame), .mf_resync(mf_resync)
);

// File: tb/tb_cas_mf_align.sv
module tb_cas_mf_align;
  logic clk = 1'b0, rst_n = 1'b0, ext_mode = 1'b0, ts_valid = 1'b0;
  logic [7:0] ts_data = '0;
  logic ts_ready, mf_locked, mf_resync;
  logic [3:0] mf_frame;
  int checks = 0, errors = 0;
  logic mode_v = 1'b0;
  int e_frame = 0;

  typedef struct packed { logic l; logic [3:0] f; logic r; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  cas_mf_align dut (.clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .ts_valid(ts_valid),
    .ts_ready(ts_ready), .ts_data(ts_data), .mf_locked(mf_locked), .mf_frame(mf_frame),
    .mf_resync(mf_resync));

  task automatic check(input string tag, input logic l, input logic [3:0] f, input logic r);
    checks++;
    if (mf_locked !== l || mf_frame !== f || mf_resync !== r || ts_ready !== 1'b1) begin
      errors++;
      $display("FAIL %s: got lock=%b frame=%0d resync=%b ready=%b exp lock=%b frame=%0d resync=%b ready=1",
               tag, mf_locked, mf_frame, mf_resync, ts_ready, l, f, r);
    end
  endtask

  // monitor: a byte taken at a rising edge is judged at the next falling edge
  always begin
    logic took;
    @(posedge clk);
    took = ts_valid;
    @(negedge clk);
    if (took && exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, e.l, e.f, e.r);
    end
  end

  task automatic send(input logic [7:0] b, input logic l, input int f, input logic r,
                      input string tag);
    @(negedge clk);
    ts_valid = 1'b1;
    ts_data  = b;
    ext_mode = mode_v;
    exp_q.push_back('{l: l, f: 4'(f), r: r});
    tag_q.push_back(tag);
    e_frame = f;
  endtask

  task automatic run_locked(input int n, input logic [7:0] b, input string tag);
    for (int i = 0; i < n; i++) send(b, 1'b1, (e_frame + 1) % 16, 1'b0, tag);
  endtask

  task automatic idle(input int n, input logic l, input string tag);
    @(negedge clk);
    ts_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, l, 4'(e_frame), 1'b0);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got no completion, exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, 4'd0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 1'b0, 4'd0, 1'b0);
    // acquisition rules
    send(8'h05, 1'b0, 0, 1'b0, "R4 pattern after zero byte rejected");
    send(8'h80, 1'b0, 0, 1'b0, "R3 0x80 is not a pattern");
    send(8'h0B, 1'b1, 0, 1'b0, "R4 pattern after nonzero accepted");
    idle(3, 1'b1, "R2 idle holds state");
    run_locked(15, 8'h55, "R5 frame count");
    run_locked(1, 8'h0F, "R5 wrap to frame 0");
    run_locked(15, 8'h55, "R5 second multiframe");
    run_locked(1, 8'h1F, "R6 single errored pattern kept");
    run_locked(15, 8'h55, "R6 counting continues");
    run_locked(1, 8'h00, "R6 correct pattern clears");
    run_locked(15, 8'h55, "R6 fill");
    run_locked(1, 8'h90, "R6 first error again kept");
    run_locked(15, 8'h55, "R7 fill");
    send(8'hA0, 1'b0, 0, 1'b1, "R7 second error resync");
    idle(1, 1'b0, "R7 resync one cycle");
    send(8'h03, 1'b1, 0, 1'b0, "R9 relock on next byte");
    run_locked(15, 8'h00, "R8 basic zero fill");
    run_locked(16, 8'h00, "R8 basic all-zero multiframe no resync");
    run_locked(15, 8'h00, "R10 zero frames 0-14");
    mode_v = 1'b1;
    send(8'h00, 1'b0, 0, 1'b1, "R10 mode set at frame 15 resync");
    send(8'h00, 1'b0, 0, 1'b0, "R9 zero predecessor no lock");
    send(8'h10, 1'b0, 0, 1'b0, "R3 0x10 is not a pattern");
    send(8'h00, 1'b1, 0, 1'b0, "R4 lock after 0x10");
    run_locked(14, 8'h00, "R8 ext zero fill");
    run_locked(1, 8'h01, "R8 one set bit prevents resync");
    run_locked(15, 8'h00, "R8 ext zero frames 0-14");
    send(8'h00, 1'b0, 0, 1'b1, "R8 ext all-zero multiframe resync");
    idle(2, 1'b0, "R2 idle after resync");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule